// File: doc/BRIEF.md
# Dual-Channel Even/Odd Pixel Distributor

This block takes one pixel stream (pixel word, horizontal sync, vertical sync, data enable) clocked at the pixel rate. It feeds the transmit lanes of a flat-panel link. With the mode input low, the stream is registered onto channel A, channel B stays at zero, and the serializer load strobe is high on every cycle.

With the mode input high, the stream is split into two half-rate channels. The pixel on which data enable goes active is always the even pixel of its pair and goes to channel A. The pixel after it goes to channel B. Both halves of a pair are presented together, and the one-cycle load strobe fires, only once the odd pixel has been taken in. The 7-bit serializers then shift at 3.5 times the pixel rate.

In this mode every horizontal interval (active, blank, sync and non-sync) has to span a whole number of pixel pairs. A sticky flag reports any interval that does not, and the clear input resets it.

Top module: `pix_pair_split`

## Requirements
- R1: While rst_n is low, every data, sync and enable output of both channels, load and align_err are 0.
- R2: With dual_mode low, a_data, a_hs, a_vs and a_de equal the inputs of the previous clock edge, and b_data, b_hs, b_vs and b_de are 0.
- R3: With dual_mode low, load is 1 on every cycle, and no odd-length interval sets align_err.
- R4: With dual_mode high, the pixel phase restarts on every rising edge of in_de. That pixel appears on channel A. The next pixel appears on channel B. Both are presented on the edge at which the second pixel is sampled, with a_de and b_de taken from their own pixels.
- R5: With dual_mode high, load is a one-cycle pulse, high exactly after each pair is presented and never on two cycles in a row. Between pulses the channel outputs hold their values.
- R6: With dual_mode high, both channels carry the hsync and vsync values sampled with the even pixel of the pair. The values sampled with the odd pixel are dropped.
- R7: With dual_mode high, if in_de is low where the odd pixel of a started pair is due, the pair is presented with the pending pixel on channel A and with b_data and b_de forced to 0, and align_err is set.
- R8: With dual_mode high, a level change of in_de or in_hs whose distance from that signal's previous change is odd sets align_err. The first change of each signal after dual_mode rises only sets the reference.
- R9: align_err stays at 1 until err_clr is sampled high. A new error in the same cycle as err_clr leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 = split into two channels, 0 = channel A only |
| in_data | input | PIX_W | Incoming pixel word |
| in_hs | input | 1 | Incoming horizontal sync |
| in_vs | input | 1 | Incoming vertical sync |
| in_de | input | 1 | Incoming data enable |
| err_clr | input | 1 | Clears the alignment flag |
| a_data | output | PIX_W | Channel A pixel (even pixels in dual mode) |
| a_hs | output | 1 | Channel A horizontal sync |
| a_vs | output | 1 | Channel A vertical sync |
| a_de | output | 1 | Channel A data enable |
| b_data | output | PIX_W | Channel B pixel (odd pixels in dual mode) |
| b_hs | output | 1 | Channel B horizontal sync |
| b_vs | output | 1 | Channel B vertical sync |
| b_de | output | 1 | Channel B data enable |
| load | output | 1 | Serializer load strobe |
| align_err | output | 1 | Sticky horizontal alignment error |

## Verification
Two functions can act in the same cycle. One is the truncated-pair emission, where the pending pixel goes out on A with B forced to zero. The other is the alignment flag being set while software clears it. The bench ends an active run after three pixels and holds err_clr high on that same cycle. It expects a pulse on load, the third pixel on A, zero data and enable on B, and align_err still at 1. On the cycle after, with err_clr still high and no new fault, it expects the flag at 0. A separate sequence restarts data enable at an odd free-running position and checks that the first pixel still lands on A.

// File: rtl/pix_pair_split.sv
module pix_pair_split #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_mode,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic             in_de,
  input  logic             err_clr,
  output logic [PIX_W-1:0] a_data,
  output logic             a_hs,
  output logic             a_vs,
  output logic             a_de,
  output logic [PIX_W-1:0] b_data,
  output logic             b_hs,
  output logic             b_vs,
  output logic             b_de,
  output logic             load,
  output logic             align_err
);

  logic             de_q, hs_q;
  logic             ph, tgl;
  logic             par_de, par_hs, v_de, v_hs;
  logic [PIX_W-1:0] h_data;
  logic             h_hs, h_vs, h_de;

  wire de_rise    = in_de & ~de_q;
  wire ph_cur     = ph & ~de_rise;
  wire de_chg     = in_de ^ de_q;
  wire hs_chg     = in_hs ^ hs_q;
  wire short_pair = ph_cur & h_de & ~in_de;
  wire bad_de     = de_chg & v_de & (tgl ^ par_de);
  wire bad_hs     = hs_chg & v_hs & (tgl ^ par_hs);
  wire err_set    = dual_mode & (bad_de | bad_hs | short_pair);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q      <= 1'b0;
      hs_q      <= 1'b0;
      tgl       <= 1'b0;
      align_err <= 1'b0;
      par_de    <= 1'b0;
      par_hs    <= 1'b0;
      v_de      <= 1'b0;
      v_hs      <= 1'b0;
    end else begin
      de_q <= in_de;
      hs_q <= in_hs;
      tgl  <= ~tgl;
      if (err_set)      align_err <= 1'b1;
      else if (err_clr) align_err <= 1'b0;
      if (!dual_mode) begin
        v_de <= 1'b0;
        v_hs <= 1'b0;
      end else begin
        if (de_chg) begin
          par_de <= tgl;
          v_de   <= 1'b1;
        end
        if (hs_chg) begin
          par_hs <= tgl;
          v_hs   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      load   <= 1'b0;
      h_data <= '0;
      h_hs   <= 1'b0;
      h_vs   <= 1'b0;
      h_de   <= 1'b0;
      a_data <= '0;
      a_hs   <= 1'b0;
      a_vs   <= 1'b0;
      a_de   <= 1'b0;
      b_data <= '0;
      b_hs   <= 1'b0;
      b_vs   <= 1'b0;
      b_de   <= 1'b0;
    end else if (!dual_mode) begin
      ph     <= 1'b0;
      load   <= 1'b1;
      a_data <= in_data;
      a_hs   <= in_hs;
      a_vs   <= in_vs;
      a_de   <= in_de;
      b_data <= '0;
      b_hs   <= 1'b0;
      b_vs   <= 1'b0;
      b_de   <= 1'b0;
    end else begin
      ph   <= ~ph_cur;
      load <= ph_cur;
      if (!ph_cur) begin
        h_data <= in_data;
        h_hs   <= in_hs;
        h_vs   <= in_vs;
        h_de   <= in_de;
      end else begin
        a_data <= h_data;
        a_hs   <= h_hs;
        a_vs   <= h_vs;
        a_de   <= h_de;
        b_data <= short_pair ? '0 : in_data;
        b_de   <= in_de & ~short_pair;
        b_hs   <= h_hs;
        b_vs   <= h_vs;
      end
    end
  end

endmodule

// File: rtl/pix_pair_split_chk.sv
module pix_pair_split_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dual_mode,
  input logic             err_clr,
  input logic [PIX_W-1:0] b_data,
  input logic             a_hs,
  input logic             a_vs,
  input logic             a_de,
  input logic             b_hs,
  input logic             b_vs,
  input logic             b_de,
  input logic             load,
  input logic             align_err
);

  a_r2_single_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |=> (b_data == '0 && !b_de && !b_hs && !b_vs));

  a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |=> load);

  a_r5_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && load) |=> !load);

  a_r6_sync_copy: assert property (@(posedge clk) disable iff (!rst_n)
    dual_mode |=> (!load || (b_hs == a_hs && b_vs == a_vs)));

  a_r7_short_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && a_de && !b_de) |-> (b_data == '0));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !err_clr) |=> align_err);

endmodule

bind pix_pair_split pix_pair_split_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .err_clr(err_clr),
  .b_data(b_data), .a_hs(a_hs), .a_vs(a_vs), .a_de(a_de),
  .b_hs(b_hs), .b_vs(b_vs), .b_de(b_de), .load(load), .align_err(align_err)
);

// File: tb/pix_pair_split_test.sv
`timescale 1ns/1ps
module pix_pair_split_test;
  localparam int W = 8;
  localparam int NV = 20;

  logic         clk = 1'b0;
  logic         rst_n, dual_mode, in_hs, in_vs, in_de, err_clr;
  logic [W-1:0] in_data;
  logic [W-1:0] a_data, b_data;
  logic         a_hs, a_vs, a_de, b_hs, b_vs, b_de, load, align_err;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  pix_pair_split #(.PIX_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .in_data(in_data),
    .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de), .err_clr(err_clr),
    .a_data(a_data), .a_hs(a_hs), .a_vs(a_vs), .a_de(a_de),
    .b_data(b_data), .b_hs(b_hs), .b_vs(b_vs), .b_de(b_de),
    .load(load), .align_err(align_err)
  );

  // {clr,de,hs,vs,data} -> {load,a_data,b_data,a_de,b_de,hs,vs,err}
  localparam logic [33:0] VEC [0:NV-1] = '{
    {4'b0010, 8'h00, 1'b0, 8'h00, 8'h00, 5'b00000},
    {4'b0010, 8'h00, 1'b1, 8'h00, 8'h00, 5'b00100},
    {4'b0001, 8'h00, 1'b0, 8'h00, 8'h00, 5'b00100},
    {4'b0000, 8'h00, 1'b1, 8'h00, 8'h00, 5'b00010},
    {4'b0100, 8'h11, 1'b0, 8'h00, 8'h00, 5'b00010},
    {4'b0100, 8'h22, 1'b1, 8'h11, 8'h22, 5'b11000},
    {4'b0100, 8'h33, 1'b0, 8'h11, 8'h22, 5'b11000},
    {4'b0100, 8'h44, 1'b1, 8'h33, 8'h44, 5'b11000},
    {4'b0000, 8'h00, 1'b0, 8'h33, 8'h44, 5'b11000},
    {4'b0000, 8'h00, 1'b1, 8'h00, 8'h00, 5'b00000},
    {4'b0100, 8'h55, 1'b0, 8'h00, 8'h00, 5'b00000},
    {4'b0100, 8'h66, 1'b1, 8'h55, 8'h66, 5'b11000},
    {4'b0100, 8'h77, 1'b0, 8'h55, 8'h66, 5'b11000},
    {4'b0000, 8'hEE, 1'b1, 8'h77, 8'h00, 5'b10001},
    {4'b0000, 8'h00, 1'b0, 8'h77, 8'h00, 5'b10001},
    {4'b0100, 8'h88, 1'b0, 8'h77, 8'h00, 5'b10001},
    {4'b0100, 8'h99, 1'b1, 8'h88, 8'h99, 5'b11001},
    {4'b0100, 8'hAA, 1'b0, 8'h88, 8'h99, 5'b11001},
    {4'b1000, 8'hBB, 1'b1, 8'hAA, 8'h00, 5'b10001},
    {4'b1000, 8'h00, 1'b0, 8'hAA, 8'h00, 5'b10000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic de, input logic hs, input logic vs, input logic [W-1:0] d);
    err_clr = c; in_de = de; in_hs = hs; in_vs = vs; in_data = d;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dual_mode = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {a_data, b_data, a_hs, a_vs, a_de, b_hs, b_vs, b_de}, '0);
    check("R1 reset load/err", {load, align_err}, 2'b00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][33], VEC[i][32], VEC[i][31], VEC[i][30], VEC[i][29:22]);
      @(negedge clk);
      check($sformatf("R5 load row %0d", i), load, VEC[i][21]);
      check($sformatf("R4 a_data row %0d", i), a_data, VEC[i][20:13]);
      check($sformatf("R4 b_data row %0d", i), b_data, VEC[i][12:5]);
      check($sformatf("R4 a_de/b_de row %0d", i), {a_de, b_de}, VEC[i][4:3]);
      check($sformatf("R6 sync row %0d", i), {a_hs, a_vs, b_hs, b_vs}, {VEC[i][2:1], VEC[i][2:1]});
      check($sformatf("R8 align_err row %0d", i), align_err, VEC[i][0]);
      if (i == 13) check("R7 truncated pair B zero and err", {b_data, b_de, align_err}, {8'h00, 1'b0, 1'b1});
      if (i == 18) check("R9 set wins over clear", align_err, 1'b1);
      if (i == 19) check("R9 clear takes effect", align_err, 1'b0);
    end

    dual_mode = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h5A);
    @(negedge clk);
    check("R2 single A copy", {a_data, a_hs, a_vs, a_de}, {8'h5A, 3'b101});
    check("R2 single B zero", {b_data, b_hs, b_vs, b_de}, '0);
    check("R3 single load", load, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5);
    @(negedge clk);
    check("R2 single A copy 2", {a_data, a_hs, a_vs, a_de}, {8'hA5, 3'b010});
    check("R3 single load 2", load, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h3C);
    @(negedge clk);
    check("R3 no alignment error in single mode", align_err, 1'b0);

    dual_mode = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h01);
    @(negedge clk);
    check("R8 first change sets reference only", {align_err, load}, 2'b00);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h02);
    @(negedge clk);
    check("R8 odd hsync run flagged", align_err, 1'b1);
    check("R6 even-pixel hsync on both", {load, a_hs, b_hs}, 3'b111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule